// File: doc/BRIEF.md
# Printer Port Mode Selector and Interrupt Controller

This block is the register set and mode controller of an enhanced printer port. A host reaches four byte-wide registers through a small access port: a data register (write sets the outgoing byte, read returns the incoming byte), a status register built from the printer status pins, a control register that drives the printer control pins and the data direction, and an extended configuration register that selects the transfer mode. The handshake sequencers for the enhanced modes and the mailbox datapath are outside this block. They connect to it through the one-hot mode output, the two configuration outputs and the incoming buffer load strobe.

There are four modes and only one is active at a time: standard, EPP, ECP and a self-locking mailbox mode. The mailbox mode can only be entered with a key bit. After that it holds until reset, or until the I/O-space enable input drops. Each mode has its own interrupt source. In standard and EPP modes it is an ACK rising edge, in ECP mode an ERROR falling edge, and in mailbox mode a rising edge on the mailbox interrupt pin. Each flag has its own clearing rule. The control register gates an active-low interrupt request. All printer pin inputs pass through a two-stage synchronizer before any edge detection.

The access port is plain register control with no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. `bus_rdata` is combinational from `bus_addr`. A read side effect (flag set or clear) happens at the clock edge where `bus_rd` is high.

Top module: `pport_modectl`

## Requirements
- R1: `mode_oh` is always one-hot. Bit 0 is standard, bit 1 EPP, bit 2 ECP and bit 3 mailbox. Priority is mailbox first, then ECP (config bit 0), then EPP (config bit 2), then standard.
- R2: A write to the config register (address 3) stores bits 3..0. The mailbox bit (bit 6) changes only when bit 7 of the same write is 1. Bits 7 and 5 always read 0. Writes never change bit 4 (the ECP interrupt flag).
- R3: While mailbox mode is active, writes to the mailbox bit are ignored and the EPP and ECP bits do not change the mode. Mailbox mode is left only by reset, or by `io_en` being low at a clock edge.
- R4: After reset the registers read as follows: control 0xC0, config 0x00, data-out 0x00 on `pd_out`, incoming buffer 0xFF. The mode is standard and `irq_n` is high.
- R5: The control register (address 2) reads bits 7..6 as 1, and bits 5..0 as last written. Bit 5 high releases the data pins (`pd_oe` low). Bits 4, 2 and 1 high drive `selin_n`, `autofd_n` and `strobe_n` low. Bit 3 low drives `init_n` low.
- R6: The status register (address 1) reads as follows: bit 7 is the inverted BUSY, bit 6 ACK, bit 5 PE, bit 4 SELECT, bit 3 ERROR (each after synchronization), bits 2..1 are 1, and bit 0 is the inverted interrupt flag.
- R7: In standard and EPP modes, a synchronized ACK rising edge clears status bit 0. A status read sets it back to 1. If both happen at the same edge, the edge wins. In ECP mode, ACK edges leave the bit unchanged.
- R8: In ECP mode, a synchronized ERROR falling edge sets config bit 4. The config read that sees the flag returns it as 1 and clears it.
- R9: In mailbox mode, a synchronized rising edge on `mbx_intr_i` clears status bit 0, with the same set-on-read rule as R7.
- R10: `irq_n` is low only when control bit 0 is 1 and the active mode's flag is pending (config bit 4 in ECP mode, status bit 0 equal to 0 otherwise). `irq_n` is registered one cycle after the flag.
- R11: A write to the data register (address 0) drives `pd_out`. A read returns `pd_in` live in standard mode. In any other mode it returns the buffer that `buf_load` fills from `buf_data`.
- R12: `epp_addr_sel` follows config bit 3 and `ecp_reverse` follows config bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_en | input | 1 | I/O space enable. Low clears mailbox mode |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pd_in | input | 8 | Printer data pins, input side |
| pd_out | output | 8 | Printer data pins, output side |
| pd_oe | output | 1 | Data pin output enable |
| busy_i | input | 1 | BUSY pin |
| ack_i | input | 1 | ACK pin |
| pe_i | input | 1 | Paper-empty pin |
| slct_i | input | 1 | SELECT pin |
| err_i | input | 1 | ERROR pin |
| mbx_intr_i | input | 1 | Mailbox peer interrupt pin |
| buf_load | input | 1 | Load strobe for incoming buffer |
| buf_data | input | 8 | Incoming buffer data |
| strobe_n | output | 1 | Strobe pin, active low |
| autofd_n | output | 1 | Auto-feed pin, active low |
| init_n | output | 1 | Init pin, active low |
| selin_n | output | 1 | Select-in pin, active low |
| epp_addr_sel | output | 1 | EPP address/data select |
| ecp_reverse | output | 1 | ECP reverse direction |
| mode_oh | output | 4 | One-hot active mode |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench targets the mailbox key and lock. A design that ignored the key would fall into mailbox mode on a plain write of bit 6. A design without the lock would leave it on a later keyed write of 0 or on an ECP bit. A design that forgot `io_en` would stay locked forever. It also checks ECP-over-EPP priority and the per-mode interrupt sources. A design with a shared source would raise `irq_n` on ACK in ECP mode or miss the ERROR fall. Finally, it checks that the config read returns the ECP flag before clearing it, so a clear-before-read design would hide the interrupt.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    RA_DATA = 2'd0,
    RA_STAT = 2'd1,
    RA_CTRL = 2'd2,
    RA_XCFG = 2'd3
  } reg_addr_e;

  // one-hot mode indices
  localparam int MODE_N  = 4;
  localparam int MI_STD  = 0;
  localparam int MI_EPP  = 1;
  localparam int MI_ECP  = 2;
  localparam int MI_MBX  = 3;

  // extended configuration bit positions
  localparam int XB_KEY  = 7;
  localparam int XB_MBX  = 6;
  localparam int XB_EINT = 4;
  localparam int XB_EADR = 3;
  localparam int XB_EPP  = 2;
  localparam int XB_EDIR = 1;
  localparam int XB_ECP  = 0;
  localparam int XFLD_W  = 4;

  // control bit positions
  localparam int CB_DIR  = 5;
  localparam int CB_SLIN = 4;
  localparam int CB_INIT = 3;
  localparam int CB_AFD  = 2;
  localparam int CB_STB  = 1;
  localparam int CB_IEN  = 0;
  localparam int CTL_W   = 6;

  // synchronized pin vector indices
  localparam int PIN_N   = 6;
  localparam int PI_BUSY = 0;
  localparam int PI_ACK  = 1;
  localparam int PI_PE   = 2;
  localparam int PI_SLCT = 3;
  localparam int PI_ERR  = 4;
  localparam int PI_MINT = 5;
endpackage

// File: rtl/pport_edge_sync.sv
module pport_edge_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= IDLE;
        else        stg[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= IDLE;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= stg[STAGES-1];
  end

  assign q    = stg[STAGES-1];
  assign rise = stg[STAGES-1] & ~prev_q;
  assign fall = ~stg[STAGES-1] & prev_q;
endmodule

// File: rtl/pport_mode.sv
module pport_mode
  import pport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_en,
  input  logic              wr_en,
  input  logic              wkey,
  input  logic              wmbx,
  input  logic [XFLD_W-1:0] wfield,
  output logic              mbx_q,
  output logic [XFLD_W-1:0] fld_q,
  output logic [MODE_N-1:0] mode_oh
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mbx_q <= 1'b0;
      fld_q <= '0;
    end else begin
      if (!io_en)
        mbx_q <= 1'b0;
      else if (wr_en && wkey && !mbx_q)
        mbx_q <= wmbx;
      if (wr_en)
        fld_q <= wfield;
    end
  end

  always_comb begin
    mode_oh = '0;
    if (mbx_q)               mode_oh[MI_MBX] = 1'b1;
    else if (fld_q[XB_ECP])  mode_oh[MI_ECP] = 1'b1;
    else if (fld_q[XB_EPP])  mode_oh[MI_EPP] = 1'b1;
    else                     mode_oh[MI_STD] = 1'b1;
  end
endmodule

// File: rtl/pport_irq.sv
module pport_irq
  import pport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_N-1:0] mode_oh,
  input  logic              ack_rise,
  input  logic              err_fall,
  input  logic              mint_rise,
  input  logic              rd_stat,
  input  logic              rd_xcfg,
  input  logic              inten,
  output logic              intflag_n,
  output logic              ecp_flag,
  output logic              irq_n
);
  logic hit_n;
  logic pend;

  assign hit_n = ((mode_oh[MI_STD] | mode_oh[MI_EPP]) & ack_rise) |
                 (mode_oh[MI_MBX] & mint_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intflag_n <= 1'b1;
      ecp_flag  <= 1'b0;
      irq_n     <= 1'b1;
    end else begin
      if (hit_n)        intflag_n <= 1'b0;
      else if (rd_stat) intflag_n <= 1'b1;
      if (mode_oh[MI_ECP] && err_fall) ecp_flag <= 1'b1;
      else if (rd_xcfg)                ecp_flag <= 1'b0;
      irq_n <= ~(inten & pend);
    end
  end

  assign pend = mode_oh[MI_ECP] ? ecp_flag : ~intflag_n;
endmodule

// File: rtl/pport_modectl.sv
module pport_modectl
  import pport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_en,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic [REG_W-1:0] pd_in,
  output logic [REG_W-1:0] pd_out,
  output logic             pd_oe,
  input  logic             busy_i,
  input  logic             ack_i,
  input  logic             pe_i,
  input  logic             slct_i,
  input  logic             err_i,
  input  logic             mbx_intr_i,
  input  logic             buf_load,
  input  logic [REG_W-1:0] buf_data,
  output logic             strobe_n,
  output logic             autofd_n,
  output logic             init_n,
  output logic             selin_n,
  output logic             epp_addr_sel,
  output logic             ecp_reverse,
  output logic [MODE_N-1:0] mode_oh,
  output logic             irq_n
);
  localparam logic [CTL_W-1:0] CTL_RST  = '0;
  localparam logic [REG_W-1:0] DBUF_RST = '1;

  reg_addr_e          ra;
  logic               wr_data, wr_ctrl, wr_xcfg, rd_stat, rd_xcfg;
  logic [REG_W-1:0]   dout_q, dbuf_q;
  logic [CTL_W-1:0]   ctl_q;
  logic [PIN_N-1:0]   pin_raw, pin_s, pin_r, pin_f;
  logic               mbx_q;
  logic [XFLD_W-1:0]  fld_q;
  logic               intflag_n, ecp_flag;

  assign ra      = reg_addr_e'(bus_addr);
  assign wr_data = bus_wr && (ra == RA_DATA);
  assign wr_ctrl = bus_wr && (ra == RA_CTRL);
  assign wr_xcfg = bus_wr && (ra == RA_XCFG);
  assign rd_stat = bus_rd && (ra == RA_STAT);
  assign rd_xcfg = bus_rd && (ra == RA_XCFG);

  assign pin_raw[PI_BUSY] = busy_i;
  assign pin_raw[PI_ACK]  = ack_i;
  assign pin_raw[PI_PE]   = pe_i;
  assign pin_raw[PI_SLCT] = slct_i;
  assign pin_raw[PI_ERR]  = err_i;
  assign pin_raw[PI_MINT] = mbx_intr_i;

  pport_edge_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .IDLE('1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_raw),
    .q    (pin_s),
    .rise (pin_r),
    .fall (pin_f)
  );

  pport_mode u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .io_en  (io_en),
    .wr_en  (wr_xcfg),
    .wkey   (bus_wdata[XB_KEY]),
    .wmbx   (bus_wdata[XB_MBX]),
    .wfield (bus_wdata[XFLD_W-1:0]),
    .mbx_q  (mbx_q),
    .fld_q  (fld_q),
    .mode_oh(mode_oh)
  );

  pport_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_oh  (mode_oh),
    .ack_rise (pin_r[PI_ACK]),
    .err_fall (pin_f[PI_ERR]),
    .mint_rise(pin_r[PI_MINT]),
    .rd_stat  (rd_stat),
    .rd_xcfg  (rd_xcfg),
    .inten    (ctl_q[CB_IEN]),
    .intflag_n(intflag_n),
    .ecp_flag (ecp_flag),
    .irq_n    (irq_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      ctl_q  <= CTL_RST;
      dbuf_q <= DBUF_RST;
    end else begin
      if (wr_data)  dout_q <= bus_wdata;
      if (wr_ctrl)  ctl_q  <= bus_wdata[CTL_W-1:0];
      if (buf_load) dbuf_q <= buf_data;
    end
  end

  assign pd_out       = dout_q;
  assign pd_oe        = ~ctl_q[CB_DIR];
  assign selin_n      = ~ctl_q[CB_SLIN];
  assign init_n       =  ctl_q[CB_INIT];
  assign autofd_n     = ~ctl_q[CB_AFD];
  assign strobe_n     = ~ctl_q[CB_STB];
  assign epp_addr_sel = fld_q[XB_EADR];
  assign ecp_reverse  = fld_q[XB_EDIR];

  always_comb begin
    bus_rdata = '0;
    unique case (ra)
      RA_DATA: bus_rdata = mode_oh[MI_STD] ? pd_in : dbuf_q;
      RA_STAT: bus_rdata = {~pin_s[PI_BUSY], pin_s[PI_ACK], pin_s[PI_PE],
                            pin_s[PI_SLCT], pin_s[PI_ERR], 2'b11, intflag_n};
      RA_CTRL: bus_rdata = {2'b11, ctl_q};
      RA_XCFG: bus_rdata = {1'b0, mbx_q, 1'b0, ecp_flag, fld_q};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pport_modectl_chk.sv
module pport_modectl_chk
  import pport_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              io_en,
  input logic [1:0]        bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic [MODE_N-1:0] mode_oh,
  input logic              irq_n,
  input logic              inten
);
  // R1: exactly one mode active
  a_r1_mode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_oh) == 1);

  // R2: config write without key leaves mailbox state alone
  a_r2_no_key_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3 && !bus_wdata[XB_KEY] && io_en)
      |=> $stable(mode_oh[MI_MBX]));

  // R2: key bit never reads back
  a_r2_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> !bus_rdata[XB_KEY]);

  // R3: mailbox mode holds while I/O space stays enabled
  a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh[MI_MBX] && io_en) |=> mode_oh[MI_MBX]);

  // R10: request only with enable set
  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n) |-> $past(inten));
endmodule

bind pport_modectl pport_modectl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .io_en    (io_en),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .mode_oh  (mode_oh),
  .irq_n    (irq_n),
  .inten    (ctl_q[0])
);

// File: tb/pport_modectl_tb_top.sv
module pport_modectl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_en = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pd_in = 8'hFF;
  logic [7:0] pd_out;
  logic pd_oe;
  logic busy_i = 1'b0, ack_i = 1'b1, pe_i = 1'b0, slct_i = 1'b1, err_i = 1'b1, mbx_intr_i = 1'b1;
  logic buf_load = 1'b0;
  logic [7:0] buf_data = 8'h00;
  logic strobe_n, autofd_n, init_n, selin_n, epp_addr_sel, ecp_reverse, irq_n;
  logic [3:0] mode_oh;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pport_modectl dut_i (.*);

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; io_en = 1'b1;
    settle(2); rst_n = 1'b1; settle(1);
  endtask

  function automatic logic [3:0] exp_mode(logic mbx, logic [3:0] f);
    if (mbx) return 4'b1000;
    if (f[0]) return 4'b0100;
    if (f[2]) return 4'b0010;
    return 4'b0001;
  endfunction

  function automatic logic [7:0] exp_stat(logic b, logic a, logic p, logic s, logic e);
    return {~b, a, p, s, e, 3'b111};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic exp_mbx;
    logic [3:0] exp_fld;
    void'($urandom(32'h5eed_0042));
    do_reset();

    // R4 reset state
    rd(2'd2, r); chk("R4 ctrl reset", r, 8'hC0);
    rd(2'd3, r); chk("R4 xcfg reset", r, 8'h00);
    chk("R4 pd_out reset", pd_out, 8'h00);
    chk("R4 mode reset", {4'h0, mode_oh}, 8'h01);
    chk("R4 irq_n reset", {7'h0, irq_n}, 8'h01);
    chk("R5 reset pins", {3'b0, pd_oe, selin_n, init_n, autofd_n, strobe_n}, 8'b000_1_1_0_1_1);
    rd(2'd1, r); chk("R6 status idle", r, exp_stat(0, 1, 0, 1, 1));

    // R5 random control writes
    for (int i = 0; i < 24; i++) begin
      logic [7:0] w;
      w = 8'($urandom);
      w[0] = 1'b0;
      wr(2'd2, w);
      rd(2'd2, r); chk("R5 ctrl readback", r, {2'b11, w[5:0]});
      chk("R5 pin map", {3'b0, pd_oe, selin_n, init_n, autofd_n, strobe_n},
          {3'b0, ~w[5], ~w[4], w[3], ~w[2], ~w[1]});
    end
    wr(2'd2, 8'h00);

    // R11 data out and live input in standard mode
    for (int i = 0; i < 8; i++) begin
      logic [7:0] w;
      w = 8'($urandom);
      wr(2'd0, w); chk("R11 pd_out", pd_out, w);
      pd_in = 8'($urandom);
      rd(2'd0, r); chk("R11 live pd_in", r, pd_in);
    end

    // R6 random status pin patterns
    for (int i = 0; i < 16; i++) begin
      logic [4:0] p;
      p = 5'($urandom);
      @(negedge clk); {busy_i, ack_i, pe_i, slct_i, err_i} = p;
      settle(4);
      rd(2'd1, r);
      chk("R6 status bits", {r[7:1], 1'b1}, exp_stat(p[4], p[3], p[2], p[1], p[0]));
    end
    @(negedge clk); busy_i = 0; ack_i = 1; pe_i = 0; slct_i = 1; err_i = 1;
    settle(4); rd(2'd1, r);

    // R7 / R10 standard-mode ACK interrupt
    wr(2'd2, 8'h01);
    @(negedge clk); ack_i = 0; settle(4);
    @(negedge clk); ack_i = 1; settle(5);
    chk("R10 irq on ack rise", {7'h0, irq_n}, 8'h00);
    rd(2'd1, r); chk("R7 flag cleared", {7'h0, r[0]}, 8'h00);
    settle(3);
    chk("R10 irq released after status read", {7'h0, irq_n}, 8'h01);
    rd(2'd1, r); chk("R7 flag set by read", {7'h0, r[0]}, 8'h01);
    // R10 masked
    wr(2'd2, 8'h00);
    @(negedge clk); ack_i = 0; settle(4);
    @(negedge clk); ack_i = 1; settle(5);
    chk("R10 masked irq", {7'h0, irq_n}, 8'h01);
    rd(2'd1, r); chk("R7 flag without enable", {7'h0, r[0]}, 8'h00);

    // R2 / R3 / R1 random config writes with model
    do_reset();
    exp_mbx = 0; exp_fld = 0;
    for (int i = 0; i < 48; i++) begin
      logic [7:0] w;
      w = 8'($urandom);
      if (($urandom % 7) == 0) begin
        @(negedge clk); io_en = 0;
        @(negedge clk); io_en = 1;
        exp_mbx = 0;
      end else begin
        wr(2'd3, w);
        if (w[7] && !exp_mbx) exp_mbx = w[6];
        exp_fld = w[3:0];
      end
      chk("R1 R3 mode", {4'h0, mode_oh}, {4'h0, exp_mode(exp_mbx, exp_fld)});
      rd(2'd3, r); chk("R2 xcfg readback", r, {1'b0, exp_mbx, 2'b00, exp_fld});
      chk("R12 epp_addr_sel", {7'h0, epp_addr_sel}, {7'h0, exp_fld[3]});
      chk("R12 ecp_reverse", {7'h0, ecp_reverse}, {7'h0, exp_fld[1]});
    end

    // directed key and lock
    do_reset();
    wr(2'd3, 8'h40); chk("R2 no key no mailbox", {4'h0, mode_oh}, 8'h01);
    wr(2'd3, 8'h05); chk("R1 ECP over EPP", {4'h0, mode_oh}, 8'h04);
    wr(2'd3, 8'h04); chk("R1 EPP", {4'h0, mode_oh}, 8'h02);
    rd(2'd0, r); chk("R4 R11 buffer reset", r, 8'hFF);
    @(negedge clk); buf_data = 8'h5A; buf_load = 1; @(negedge clk); buf_load = 0;
    rd(2'd0, r); chk("R11 buffer read", r, 8'h5A);
    wr(2'd3, 8'hC0); chk("R3 mailbox entered", {4'h0, mode_oh}, 8'h08);
    rd(2'd3, r); chk("R2 key reads 0", r, 8'h40);
    wr(2'd3, 8'h81); chk("R3 keyed clear locked", {4'h0, mode_oh}, 8'h08);
    wr(2'd3, 8'h05); chk("R3 ECP bit locked", {4'h0, mode_oh}, 8'h08);
    // R9 mailbox interrupt
    wr(2'd2, 8'h01);
    @(negedge clk); mbx_intr_i = 0; settle(4);
    @(negedge clk); mbx_intr_i = 1; settle(5);
    chk("R9 mailbox irq", {7'h0, irq_n}, 8'h00);
    rd(2'd1, r); settle(3);
    chk("R9 cleared by status read", {7'h0, irq_n}, 8'h01);
    @(negedge clk); io_en = 0; @(negedge clk); io_en = 1;
    chk("R3 io_en leaves mailbox", {4'h0, mode_oh}, 8'h04);
    wr(2'd3, 8'hC0); chk("R3 re-enter", {4'h0, mode_oh}, 8'h08);
    do_reset(); chk("R3 reset leaves mailbox", {4'h0, mode_oh}, 8'h01);

    // R8 ECP interrupt
    wr(2'd3, 8'h01); wr(2'd2, 8'h01);
    @(negedge clk); ack_i = 0; settle(4);
    @(negedge clk); ack_i = 1; settle(5);
    chk("R7 ack ignored in ECP irq", {7'h0, irq_n}, 8'h01);
    rd(2'd1, r); chk("R7 ack ignored in ECP flag", {7'h0, r[0]}, 8'h01);
    @(negedge clk); err_i = 0; settle(5);
    chk("R8 irq on err fall", {7'h0, irq_n}, 8'h00);
    @(negedge clk); err_i = 1;
    wr(2'd3, 8'h11);
    rd(2'd3, r); chk("R8 flag seen on read, write ignored", r, 8'h11);
    rd(2'd3, r); chk("R8 flag cleared", r, 8'h01);
    settle(3); chk("R10 irq released", {7'h0, irq_n}, 8'h01);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule